// File: doc/BRIEF.md
# Masked Control Register with Merge Aliases

This block holds one 64-bit control word behind a simple word-addressed register bus. The same storage can be reached at three neighbouring word offsets. The first offset reads and writes the word directly. The second stores the bitwise AND of the current value and the write data. The third stores the bitwise OR of the two. Software can therefore set or clear single flags in one bus write, without a read-modify-write sequence.

Only the top 16 bits of the word are stored. Every other bit is dropped on each update and always reads as zero. The most significant stored bit drives a level interrupt line straight from the register flop.

The bus carries a byte address. The block turns it into a word offset by dropping the three lowest bits. Only full 8-byte accesses are valid. An access of any other size, an access to an unknown offset, or a read of either merge alias leaves the word unchanged and raises a one-cycle flag that marks the access as unimplemented.

Top module: `misc_ctl_reg`

## Requirements
- R1: While reset is high and on the first cycle after it, the stored word is zero, `irq` is 0, and `bus_rvalid`, `bus_unimpl` and `bus_rdata` are 0.
- R2: An 8-byte write to word offset 0x4020 (byte address 0x20100) replaces the word with the write data. An 8-byte read at that offset returns the word on `bus_rdata` in the cycle after the request.
- R3: The keep mask is 0xFFFF_0000_0000_0000. Bits 47..0 of the stored word are always zero, so they read as zero after any update.
- R4: An 8-byte write to word offset 0x4021 (byte address 0x20108) stores the current word AND the write data, masked as in R3.
- R5: An 8-byte write to word offset 0x4022 (byte address 0x20110) stores the current word OR the write data, masked as in R3.
- R6: `irq` equals bit 63 of the stored word. It changes on the clock edge that captures the write, and it holds its old value during the request cycle.
- R7: A read of offset 0x4021 or 0x4022 returns zero with `bus_rvalid` high, and it pulses `bus_unimpl`.
- R8: A read or write of any offset other than 0x4020..0x4022 leaves the word unchanged. It pulses `bus_unimpl` for one cycle, in the cycle after the request, and a read there returns zero.
- R9: An access whose `bus_size` is not 8 is ignored, whatever its offset. It pulses `bus_unimpl`, and a read returns zero.
- R10: Address bits 2..0 take no part in the decode. For example, byte addresses 0x20105 and 0x20107 both select offset 0x4020.
- R11: `bus_rvalid` is high for exactly the one cycle after each read request. It stays low after writes and after idle cycles. `bus_unimpl` is low after valid accesses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Access request, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 20 | Byte address |
| bus_size | input | 4 | Access size in bytes |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Registered read data |
| bus_rvalid | output | 1 | Read response valid, one cycle after the request |
| bus_unimpl | output | 1 | One-cycle flag for an unimplemented or badly sized access |
| irq | output | 1 | Level interrupt, bit 63 of the stored word |

## Verification
A wrong stored word shows up at the ports in two ways. The cycle after the edge that corrupts bit 63 shows it on `irq`. Any other corrupt bit is seen only at the next direct read, one cycle after that read is issued. The merge aliases depend on the value already stored, so a fault in the AND or OR path shows up as a wrong value at the next read after the merge write. A fault in the keep mask shows up as non-zero low bits in that same read. A decode fault lets a foreign or badly sized access change the word. That change is caught by the direct read that follows it, and a missing `bus_unimpl` pulse is caught one cycle after the access.

// File: rtl/misc_reg_pkg.sv
package misc_reg_pkg;

    localparam int DATA_W       = 64;
    localparam int ADDR_W       = 20;
    localparam int SIZE_W       = 4;
    localparam int ACCESS_BYTES = 8;
    localparam int WORD_SHIFT   = $clog2(ACCESS_BYTES);
    localparam int KEEP_BITS    = 16;
    localparam int DROP_BITS    = DATA_W - KEEP_BITS;

    localparam logic [ADDR_W-1:0] OFF_DIRECT = ADDR_W'(32'h4020);
    localparam logic [ADDR_W-1:0] OFF_AND    = OFF_DIRECT + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFF_OR     = OFF_DIRECT + ADDR_W'(2);

    localparam logic [DATA_W-1:0] KEEP_MASK = {{KEEP_BITS{1'b1}}, {DROP_BITS{1'b0}}};

    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_DIRECT = 2'd1,
        SEL_AND    = 2'd2,
        SEL_OR     = 2'd3
    } view_sel_e;

    function automatic logic [DATA_W-1:0] merge_word(
        input view_sel_e         sel,
        input logic [DATA_W-1:0] cur,
        input logic [DATA_W-1:0] wd
    );
        logic [DATA_W-1:0] raw;
        case (sel)
            SEL_DIRECT: raw = wd;
            SEL_AND:    raw = cur & wd;
            SEL_OR:     raw = cur | wd;
            default:    raw = cur;
        endcase
        return raw & KEEP_MASK;
    endfunction

endpackage

// File: rtl/misc_addr_decode.sv
module misc_addr_decode
    import misc_reg_pkg::*;
(
    input  logic              valid,
    input  logic              write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [SIZE_W-1:0] size,
    output view_sel_e         sel,
    output logic              wr_en,
    output logic              rd_en,
    output logic              bad
);
    logic [ADDR_W-1:0] word_off;
    logic              size_ok;

    always_comb begin
        word_off = addr >> WORD_SHIFT;
        size_ok  = (size == SIZE_W'(ACCESS_BYTES));
        if (!size_ok)                   sel = SEL_NONE;
        else if (word_off == OFF_DIRECT) sel = SEL_DIRECT;
        else if (word_off == OFF_AND)    sel = SEL_AND;
        else if (word_off == OFF_OR)     sel = SEL_OR;
        else                             sel = SEL_NONE;
    end

    assign wr_en = valid && write && (sel != SEL_NONE);
    assign rd_en = valid && !write;
    assign bad   = valid && ((sel == SEL_NONE) || (!write && (sel != SEL_DIRECT)));

endmodule

// File: rtl/misc_reg_store.sv
module misc_reg_store
    import misc_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  view_sel_e         sel,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] q
);
    logic [DATA_W-1:0] nxt;

    always_comb begin
        nxt = q;
        if (wr_en) nxt = merge_word(sel, q, wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end

endmodule

// File: rtl/misc_read_port.sv
module misc_read_port
    import misc_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  view_sel_e         sel,
    input  logic              rd_en,
    input  logic              bad,
    input  logic [DATA_W-1:0] q,
    output logic [DATA_W-1:0] rdata,
    output logic              rvalid,
    output logic              unimpl
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
            unimpl <= 1'b0;
        end else begin
            rvalid <= rd_en;
            unimpl <= bad;
            rdata  <= (rd_en && sel == SEL_DIRECT) ? q : '0;
        end
    end

endmodule

// File: rtl/misc_ctl_reg.sv
module misc_ctl_reg
    import misc_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [SIZE_W-1:0] bus_size,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    output logic              bus_unimpl,
    output logic              irq
);
    view_sel_e         sel;
    logic              wr_en;
    logic              rd_en;
    logic              bad;
    logic [DATA_W-1:0] word_q;

    misc_addr_decode u_dec (
        .valid (bus_valid),
        .write (bus_write),
        .addr  (bus_addr),
        .size  (bus_size),
        .sel   (sel),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .bad   (bad)
    );

    misc_reg_store u_store (
        .clk   (clk),
        .rst   (rst),
        .sel   (sel),
        .wr_en (wr_en),
        .wdata (bus_wdata),
        .q     (word_q)
    );

    misc_read_port u_rd (
        .clk    (clk),
        .rst    (rst),
        .sel    (sel),
        .rd_en  (rd_en),
        .bad    (bad),
        .q      (word_q),
        .rdata  (bus_rdata),
        .rvalid (bus_rvalid),
        .unimpl (bus_unimpl)
    );

    assign irq = word_q[DATA_W-1];

endmodule

// File: rtl/misc_ctl_reg_chk.sv
module misc_ctl_reg_chk
    import misc_reg_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 valid,
    input logic                 write,
    input logic [ADDR_W-1:0]    word_off,
    input logic                 size_ok,
    input logic                 wdata_msb,
    input logic [DROP_BITS-1:0] rdata_low,
    input logic                 rvalid,
    input logic                 unimpl,
    input logic                 irq
);
    logic known;
    assign known = (word_off == OFF_DIRECT) || (word_off == OFF_AND) || (word_off == OFF_OR);

    assert_reset_R1: assert property (@(posedge clk)
        rst |=> (!irq && !rvalid && !unimpl));

    assert_low_zero_R3: assert property (@(posedge clk) disable iff (rst)
        rvalid |-> (rdata_low == '0));

    assert_irq_follow_R6: assert property (@(posedge clk) disable iff (rst)
        (valid && write && size_ok && word_off == OFF_DIRECT) |=> (irq == $past(wdata_msb)));

    assert_and_clear_R4: assert property (@(posedge clk) disable iff (rst)
        (valid && write && size_ok && word_off == OFF_AND && !wdata_msb) |=> !irq);

    assert_or_set_R5: assert property (@(posedge clk) disable iff (rst)
        (valid && write && size_ok && word_off == OFF_OR && wdata_msb) |=> irq);

    assert_unknown_flag_R8: assert property (@(posedge clk) disable iff (rst)
        (valid && !known) |=> (unimpl && $stable(irq)));

    assert_size_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        (valid && !size_ok) |=> (unimpl && $stable(irq)));

    assert_rvalid_after_read_R11: assert property (@(posedge clk) disable iff (rst)
        (valid && !write) |=> rvalid);

    assert_rvalid_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        !(valid && !write) |=> !rvalid);

endmodule

bind misc_ctl_reg misc_ctl_reg_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .valid     (bus_valid),
    .write     (bus_write),
    .word_off  (bus_addr >> misc_reg_pkg::WORD_SHIFT),
    .size_ok   (bus_size == misc_reg_pkg::SIZE_W'(misc_reg_pkg::ACCESS_BYTES)),
    .wdata_msb (bus_wdata[misc_reg_pkg::DATA_W-1]),
    .rdata_low (bus_rdata[misc_reg_pkg::DROP_BITS-1:0]),
    .rvalid    (bus_rvalid),
    .unimpl    (bus_unimpl),
    .irq       (irq)
);

// File: tb/misc_ctl_reg_tb.sv
module misc_ctl_reg_tb;
    import misc_reg_pkg::*;

    localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(32'h20100);
    localparam logic [ADDR_W-1:0] A_AND = ADDR_W'(32'h20108);
    localparam logic [ADDR_W-1:0] A_OR  = ADDR_W'(32'h20110);
    localparam logic [ADDR_W-1:0] A_BAD = ADDR_W'(32'h20118);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [SIZE_W-1:0] bus_size = SIZE_W'(8);
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              bus_rvalid;
    logic              bus_unimpl;
    logic              irq;

    int checks = 0;
    int failures = 0;
    logic [DATA_W-1:0] got_rdata;
    logic got_rvalid, got_unimpl, got_irq, pre_irq;

    always #2 clk = ~clk;

    misc_ctl_reg u_dut (
        .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .bus_unimpl(bus_unimpl),
        .irq(irq)
    );

    task automatic check(input string tag, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic access(input logic w, input logic [ADDR_W-1:0] a,
                          input int sz, input logic [DATA_W-1:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = w; bus_addr = a;
        bus_size = SIZE_W'(sz); bus_wdata = d;
        #1 pre_irq = irq;
        @(negedge clk);
        got_rdata = bus_rdata; got_rvalid = bus_rvalid;
        got_unimpl = bus_unimpl; got_irq = irq;
        bus_valid = 1'b0; bus_write = 1'b0; bus_size = SIZE_W'(8);
    endtask

    task automatic read_expect(input string tag, input logic [ADDR_W-1:0] a,
                               input logic [DATA_W-1:0] exp, input logic exp_unimpl);
        access(1'b0, a, 8, '0);
        check({tag, " rdata"}, got_rdata, exp);
        check({tag, " rvalid"}, 64'(got_rvalid), 64'd1);
        check({tag, " unimpl"}, 64'(got_unimpl), 64'(exp_unimpl));
    endtask

    task automatic t_reset;
        check("R1 irq in reset", 64'(irq), 0);
        @(negedge clk); rst = 1'b0;
        @(negedge clk);
        check("R1 rdata", bus_rdata, 0);
        check("R1 rvalid", 64'(bus_rvalid), 0);
        check("R1 unimpl", 64'(bus_unimpl), 0);
        check("R1 irq", 64'(irq), 0);
        read_expect("R1 word", A_DIR, 0, 1'b0);
    endtask

    task automatic t_direct;
        access(1'b1, A_DIR, 8, 64'h1234_5678_9ABC_DEF0);
        check("R11 no rvalid on write", 64'(got_rvalid), 0);
        check("R11 no unimpl on write", 64'(got_unimpl), 0);
        read_expect("R2/R3 direct", A_DIR, 64'h1234_0000_0000_0000, 1'b0);
        @(negedge clk);
        check("R11 idle rvalid", 64'(bus_rvalid), 0);
    endtask

    task automatic t_irq;
        access(1'b1, A_DIR, 8, 64'h8000_0000_0000_00FF);
        check("R6 irq before edge", 64'(pre_irq), 0);
        check("R6 irq set", 64'(got_irq), 1);
        access(1'b1, A_DIR, 8, 64'h0);
        check("R6 irq hold before edge", 64'(pre_irq), 1);
        check("R6 irq clear", 64'(got_irq), 0);
    endtask

    task automatic t_and_or;
        access(1'b1, A_DIR, 8, 64'hFFFF_FFFF_FFFF_FFFF);
        read_expect("R3 all ones", A_DIR, 64'hFFFF_0000_0000_0000, 1'b0);
        access(1'b1, A_AND, 8, 64'h0F0F_FFFF_0000_0000);
        check("R4 irq cleared by AND", 64'(got_irq), 0);
        read_expect("R4 and", A_DIR, 64'h0F0F_0000_0000_0000, 1'b0);
        access(1'b1, A_OR, 8, 64'h8000_0000_0000_0001);
        check("R5 irq set by OR", 64'(got_irq), 1);
        read_expect("R5 or", A_DIR, 64'h8F0F_0000_0000_0000, 1'b0);
    endtask

    task automatic t_alias_read;
        read_expect("R7 and read", A_AND, 0, 1'b1);
        read_expect("R7 or read", A_OR, 0, 1'b1);
    endtask

    task automatic t_unknown;
        access(1'b1, A_BAD, 8, 64'h0);
        check("R8 unimpl write", 64'(got_unimpl), 1);
        @(negedge clk);
        check("R8 unimpl one cycle", 64'(bus_unimpl), 0);
        read_expect("R8 word kept", A_DIR, 64'h8F0F_0000_0000_0000, 1'b0);
        read_expect("R8 unknown read", ADDR_W'(0), 0, 1'b1);
    endtask

    task automatic t_size;
        access(1'b1, A_DIR, 4, 64'h0);
        check("R9 unimpl write", 64'(got_unimpl), 1);
        check("R9 irq kept", 64'(got_irq), 1);
        access(1'b1, A_AND, 1, 64'h0);
        check("R9 and size unimpl", 64'(got_unimpl), 1);
        read_expect("R9 word kept", A_DIR, 64'h8F0F_0000_0000_0000, 1'b0);
        access(1'b0, A_DIR, 4, 64'h0);
        check("R9 short read data", got_rdata, 0);
        check("R9 short read unimpl", 64'(got_unimpl), 1);
    endtask

    task automatic t_low_bits;
        access(1'b1, ADDR_W'(32'h20105), 8, 64'h5555_0000_0000_0000);
        check("R10 accepted", 64'(got_unimpl), 0);
        check("R10 irq", 64'(got_irq), 0);
        read_expect("R10 read", ADDR_W'(32'h20107), 64'h5555_0000_0000_0000, 1'b0);
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_direct();
        t_irq();
        t_and_or();
        t_alias_read();
        t_unknown();
        t_size();
        t_low_bits();
        @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule